// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front End

This block is the digital side of a two-channel 12-bit converter. A host sends 24-bit frames over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block brings these pins into the system clock domain with two-flop synchronizers. It shifts the data in on falling serial-clock edges, most significant bit first, and decodes each completed frame into a command, a channel address and a 12-bit code. It drives the two output codes, a power-down flag for each channel and a reference-enable flag to the analog side.

Each channel holds an input register and an output register. Writes land in the input register. A low load strobe moves pending input codes to the outputs, so both outputs can change in the same cycle. When the strobe is tied low, each write reaches the output directly. A falling edge on the clear pin zeroes both registers of both channels and drops any frame in progress. While clear is low, the load strobe has no effect. The clear-code flag stays up until the next frame completes. None of these pins carries a data stream, so they are plain level pins with no valid/ready handshake and no back-pressure.

Frame layout, from bit 23 down to bit 0:
- Bits 23:22 are ignored.
- Bits 21:19 hold the command.
- Bits 18:16 hold the address.
- Bits 15:4 hold the code.
- Bits 5:4 also serve as a small option field.
- Bits 3:0 are ignored.

Top module: `dac_serial_front`

## Requirements
- R1: After reset both output codes are 0, power-down is 00, reference enable is 0 and the clear-code flag is 0.
- R2: A frame is acted on only at its 24th falling serial-clock edge. Command 000 writes the code into the input register of the addressed channel and leaves the output unchanged while the load strobe is high.
- R3: If frame select returns high before the 24th falling edge, the frame is dropped and no register changes.
- R4: While the load strobe is low and clear is high, every unmasked channel with a pending input code copies it into its output register. Both channels update in the same cycle.
- R5: With the load strobe held low, the output code follows each completed write.
- R6: Command 011 writes the input register and the output register of the addressed channel only. Command 010 writes the addressed channel and then updates every channel's output from its input register.
- R7: Command 001 copies the input register of the addressed channel into its output register.
- R8: The address field selects the channel: 000 selects A, 001 selects B and 111 selects both. Any other address selects no channel.
- R9: A falling edge on clear zeroes the input and output registers of both channels and raises the clear-code flag.
- R10: While clear is low, the load strobe changes no output register.
- R11: A clear edge during a frame aborts that frame. Its remaining clocks are ignored until frame select rises again.
- R12: The clear-code flag falls only at the 24th edge of the next completed frame. An aborted frame leaves it set.
- R13: Command 100 sets the power-down flag of each addressed channel to frame bit 4. Command 101 zeroes all codes, power-down flags, mask bits and reference enable.
- R14: Command 110 loads the load-strobe mask from frame bits 5:4, where bit 4 masks channel A and bit 5 masks channel B. A masked channel ignores the strobe. Command 111 sets reference enable to frame bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears all registers to zero |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe, input to output registers |
| clr_n | input | 1 | Active-low clear, acts on its falling edge |
| code_a | output | 12 | Output register of channel A |
| code_b | output | 12 | Output register of channel B |
| pwr_down | output | 2 | Power-down flags, bit 0 for channel A and bit 1 for channel B |
| ref_en | output | 1 | Reference enable |
| clear_mode | output | 1 | High from a clear edge until the next completed frame |

## Verification
A wrong bit count or a wrong shift alignment shows at the ports as a code or a command landing in the wrong field. It is visible a few system clocks after frame select rises. A pending flag that is stale or missing shows only when a later load strobe moves the wrong value, or fails to move a value. Each strobe test therefore checks both channels. A stuck clear-code flag, or an abort that does not take effect, shows once the next frame has completed: the code still changes after an abort, or the flag stays up after a completed write.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  localparam int FRAME_W = 24;
  localparam int CODE_W  = 12;
  localparam int CMD_HI  = 21;
  localparam int ADR_HI  = 18;
  localparam int DAT_HI  = 15;
  localparam int OPT_LO  = 4;

  typedef enum logic [2:0] {
    CMD_WR_IN      = 3'b000,
    CMD_UPD_FROM   = 3'b001,
    CMD_WR_UPD_ALL = 3'b010,
    CMD_WR_UPD_ONE = 3'b011,
    CMD_PWR_DOWN   = 3'b100,
    CMD_RESET      = 3'b101,
    CMD_LD_MASK    = 3'b110,
    CMD_REF_EN     = 3'b111
  } cmd_e;
endpackage

// File: rtl/dac_edge_sync.sv
module dac_edge_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{IDLE}};
      last <= IDLE;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      last <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign fall = last & ~pipe[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int FRAME_W = 24,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sync_n,
  input  logic               sdin,
  input  logic               abort,
  output logic               commit,
  output logic [FRAME_W-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [2:0] raw, lvl, fall;
  assign raw = {sdin, sync_n, sclk};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    dac_edge_sync #(.STAGES(STAGES), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw[g]), .lvl(lvl[g]), .fall(fall[g])
    );
  end

  logic               active;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      commit <= 1'b0;
      word   <= '0;
    end else begin
      commit <= 1'b0;
      if (lvl[1] || abort) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (fall[1]) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && fall[0]) begin
        shreg <= {shreg[FRAME_W-3:0], lvl[2]};
        if (cnt == LAST) begin
          commit <= 1'b1;
          word   <= {shreg, lvl[2]};
          active <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_commit_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(!lvl[1] && !abort));
  assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero,
  input  logic              wr_in,
  input  logic              load_data,
  input  logic              load_in,
  input  logic              ldac_go,
  input  logic              masked,
  input  logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] out_q
);
  logic [CODE_W-1:0] in_q;
  logic              pend;
  logic              copy;

  assign copy = ldac_go && pend && !masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
      pend  <= 1'b0;
    end else if (zero) begin
      in_q  <= '0;
      out_q <= '0;
      pend  <= 1'b0;
    end else begin
      if (wr_in) begin
        in_q <= data;
        pend <= 1'b1;
      end
      if (load_data) begin
        out_q <= data;
        pend  <= 1'b0;
      end else if (load_in || copy) begin
        out_q <= in_q;
        if (!wr_in) pend <= 1'b0;
      end
    end
  end

  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (in_q == '0) && (out_q == '0));
  assert_strobe_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (copy && !zero && !load_data && !load_in) |=> out_q == $past(in_q));
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_front_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [1:0]        pwr_down,
  output logic              ref_en,
  output logic              clear_mode
);
  localparam int NCH = 2;

  logic [1:0] ctl_raw, ctl_lvl, ctl_fall;
  assign ctl_raw = {clr_n, ldac_n};

  for (genvar g = 0; g < 2; g++) begin : g_ctl
    dac_edge_sync #(.STAGES(STAGES), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ctl_raw[g]), .lvl(ctl_lvl[g]), .fall(ctl_fall[g])
    );
  end

  logic clr_fall, clr_lvl, ldac_go;
  assign clr_fall = ctl_fall[1];
  assign clr_lvl  = ctl_lvl[1];
  assign ldac_go  = !ctl_lvl[0] && clr_lvl;

  logic               commit;
  logic [FRAME_W-1:0] word;

  dac_frame_rx #(.FRAME_W(FRAME_W), .STAGES(STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .abort(clr_fall), .commit(commit), .word(word)
  );

  cmd_e              cmd;
  logic [2:0]        addr;
  logic [CODE_W-1:0] data;
  logic [1:0]        opt;
  logic [NCH-1:0]    sel;
  logic              unused_bits;

  assign cmd         = cmd_e'(word[CMD_HI -: 3]);
  assign addr        = word[ADR_HI -: 3];
  assign data        = word[DAT_HI -: CODE_W];
  assign opt         = word[OPT_LO +: 2];
  assign unused_bits = ^{word[FRAME_W-1:CMD_HI+1], word[OPT_LO-1:0]};

  always_comb begin
    case (addr)
      3'b000:  sel = 2'b01;
      3'b001:  sel = 2'b10;
      3'b111:  sel = 2'b11;
      default: sel = 2'b00;
    endcase
  end

  logic [NCH-1:0] ld_mask;
  logic [CODE_W-1:0] out_q [NCH];
  logic           zero_all;
  assign zero_all = clr_fall || (commit && cmd == CMD_RESET);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_in, load_data, load_in;
    assign wr_in     = commit && sel[c] &&
                       (cmd == CMD_WR_IN || cmd == CMD_WR_UPD_ALL || cmd == CMD_WR_UPD_ONE);
    assign load_data = commit && sel[c] &&
                       (cmd == CMD_WR_UPD_ALL || cmd == CMD_WR_UPD_ONE);
    assign load_in   = commit && ((cmd == CMD_UPD_FROM && sel[c]) ||
                                  (cmd == CMD_WR_UPD_ALL && !sel[c]));
    dac_chan_regs #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .zero(zero_all), .wr_in(wr_in),
      .load_data(load_data), .load_in(load_in), .ldac_go(ldac_go),
      .masked(ld_mask[c]), .data(data), .out_q(out_q[c])
    );
  end

  assign code_a = out_q[0];
  assign code_b = out_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_down   <= '0;
      ld_mask    <= '0;
      ref_en     <= 1'b0;
      clear_mode <= 1'b0;
    end else begin
      if (clr_fall) clear_mode <= 1'b1;
      else if (commit) clear_mode <= 1'b0;
      if (commit) begin
        case (cmd)
          CMD_PWR_DOWN: begin
            for (int c = 0; c < NCH; c++) if (sel[c]) pwr_down[c] <= opt[0];
          end
          CMD_RESET: begin
            pwr_down <= '0;
            ld_mask  <= '0;
            ref_en   <= 1'b0;
          end
          CMD_LD_MASK: ld_mask <= opt;
          CMD_REF_EN:  ref_en  <= opt[0];
          default: ;
        endcase
      end
    end
  end

  assert_strobe_held_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_lvl && $past(!clr_lvl) && !commit) |=> ($stable(code_a) && $stable(code_b)));
  assert_clear_flag_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_mode && !commit) |=> clear_mode);
  assert_clear_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> clear_mode);
endmodule

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic [1:0]  pwr_down;
  logic        ref_en, clear_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dac_serial_front dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .code_a(code_a), .code_b(code_b),
    .pwr_down(pwr_down), .ref_en(ref_en), .clear_mode(clear_mode)
  );

  function automatic logic [23:0] mk(input logic [2:0] cmd, input logic [2:0] adr,
                                     input logic [11:0] d);
    return {2'b00, cmd, adr, d, 4'b0000};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [23:0] w, input int first, input int last);
    for (int i = first; i < last; i++) begin
      sdin = w[23-i];
      wclk(4);
      sclk = 1'b0;
      wclk(4);
      sclk = 1'b1;
    end
  endtask

  task automatic send(input logic [23:0] w, input int nbits);
    sync_n = 1'b0;
    wclk(6);
    shift_bits(w, 0, nbits);
    wclk(4);
    sync_n = 1'b1;
    wclk(10);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    wclk(6);
    ldac_n = 1'b1;
    wclk(6);
  endtask

  task automatic t_reset();
    check("R1 code_a", code_a, 0);
    check("R1 code_b", code_b, 0);
    check("R1 pwr_down", pwr_down, 0);
    check("R1 ref_en", ref_en, 0);
    check("R1 clear_mode", clear_mode, 0);
  endtask

  task automatic t_write_hold();
    send(mk(3'b000, 3'b000, 12'h123), 24);
    send(mk(3'b000, 3'b001, 12'hABC), 24);
    check("R2 input write holds code_a", code_a, 0);
    check("R2 input write holds code_b", code_b, 0);
    pulse_ldac();
    check("R4 strobe code_a", code_a, 12'h123);
    check("R4 strobe code_b", code_b, 12'hABC);
  endtask

  task automatic t_abort();
    send(mk(3'b000, 3'b000, 12'hFFF), 20);
    send(mk(3'b001, 3'b000, 12'h000), 24);
    check("R3 short frame dropped", code_a, 12'h123);
  endtask

  task automatic t_update();
    send(mk(3'b011, 3'b000, 12'h456), 24);
    check("R6 one-channel update A", code_a, 12'h456);
    check("R6 one-channel update leaves B", code_b, 12'hABC);
    send(mk(3'b000, 3'b001, 12'h111), 24);
    send(mk(3'b010, 3'b000, 12'h222), 24);
    check("R6 update-all A", code_a, 12'h222);
    check("R6 update-all B", code_b, 12'h111);
  endtask

  task automatic t_from_input();
    send(mk(3'b000, 3'b000, 12'h333), 24);
    send(mk(3'b001, 3'b000, 12'h000), 24);
    check("R7 update from input", code_a, 12'h333);
  endtask

  task automatic t_addr();
    send(mk(3'b011, 3'b111, 12'h5A5), 24);
    check("R8 both A", code_a, 12'h5A5);
    check("R8 both B", code_b, 12'h5A5);
    send(mk(3'b011, 3'b010, 12'h777), 24);
    check("R8 unused address A", code_a, 12'h5A5);
    check("R8 unused address B", code_b, 12'h5A5);
  endtask

  task automatic t_mask_ref();
    send(mk(3'b110, 3'b000, 12'h001), 24);
    send(mk(3'b000, 3'b111, 12'h0F0), 24);
    pulse_ldac();
    check("R14 masked A holds", code_a, 12'h5A5);
    check("R14 unmasked B moves", code_b, 12'h0F0);
    send(mk(3'b110, 3'b000, 12'h000), 24);
    pulse_ldac();
    check("R14 unmask A moves", code_a, 12'h0F0);
    send(mk(3'b111, 3'b000, 12'h001), 24);
    check("R14 ref enable", ref_en, 1);
  endtask

  task automatic t_tied();
    ldac_n = 1'b0;
    wclk(6);
    send(mk(3'b000, 3'b000, 12'h9C3), 24);
    check("R5 tied strobe follows", code_a, 12'h9C3);
    ldac_n = 1'b1;
    wclk(6);
  endtask

  task automatic t_clear();
    send(mk(3'b000, 3'b001, 12'h444), 24);
    clr_n = 1'b0;
    wclk(8);
    check("R9 clear code_a", code_a, 0);
    check("R9 clear code_b", code_b, 0);
    check("R9 clear flag", clear_mode, 1);
    send(mk(3'b000, 3'b000, 12'h888), 24);
    check("R12 flag drops after write", clear_mode, 0);
    pulse_ldac();
    check("R10 strobe ignored under clear", code_a, 0);
    clr_n = 1'b1;
    wclk(6);
    pulse_ldac();
    check("R4 strobe after clear released", code_a, 12'h888);
    send(mk(3'b001, 3'b001, 12'h000), 24);
    check("R9 input register zeroed", code_b, 0);
  endtask

  task automatic t_clear_abort();
    logic [23:0] w;
    w = mk(3'b011, 3'b000, 12'hFFF);
    sync_n = 1'b0;
    wclk(6);
    shift_bits(w, 0, 12);
    clr_n = 1'b0;
    wclk(6);
    clr_n = 1'b1;
    wclk(6);
    shift_bits(w, 12, 24);
    wclk(4);
    sync_n = 1'b1;
    wclk(10);
    check("R11 aborted frame code_a", code_a, 0);
    check("R12 flag kept after abort", clear_mode, 1);
    send(mk(3'b011, 3'b000, 12'h010), 24);
    check("R12 write after abort code_a", code_a, 12'h010);
    check("R12 flag drops", clear_mode, 0);
  endtask

  task automatic t_pd_reset();
    send(mk(3'b100, 3'b001, 12'h001), 24);
    check("R13 power-down B", pwr_down, 2'b10);
    send(mk(3'b011, 3'b001, 12'h321), 24);
    send(mk(3'b101, 3'b000, 12'h000), 24);
    check("R13 reset code_a", code_a, 0);
    check("R13 reset code_b", code_b, 0);
    check("R13 reset pwr_down", pwr_down, 0);
    check("R13 reset ref_en", ref_en, 0);
  endtask

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    t_reset();
    t_write_hold();
    t_abort();
    t_update();
    t_from_input();
    t_addr();
    t_mask_ref();
    t_tied();
    t_clear();
    t_clear_abort();
    t_pd_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule